// File: doc/BRIEF.md
# DC Level Measurement Integrator

This block turns a stream of decimated, signed DC-path samples into one measured level per integration window. Each accepted sample first has a 16-bit signed correction value added, which removes offset from the sensor and the converter. It can then be multiplied by sixteen, and it can be folded to its magnitude. Before it reaches the accumulator, the sample is scaled down by a power of two. All of these stages saturate at their own width instead of wrapping. The accumulator sums a programmable number of samples. If a window's sum leaves the accumulator's range, the window result is pinned at signed full scale.

A start pulse opens a measurement. It also latches a 4-bit source tag, which travels with the result and never alters the arithmetic. At the end of each window the result register loads and a one-cycle done pulse fires. In single mode the block then goes idle. In continuous mode the next window begins with the next sample. The configuration inputs are read live on every accepted sample. In normal use, one valid strobe arrives per decimated sample period.

Top module: `dclvl_integrator`

## Requirements
- R1: The correction value is {ofs_hi_i, ofs_lo_i}, read as a 16-bit two's-complement number. It is added to the 19-bit signed sample, and the sum saturates to the range -262144..262143.
- R2: When gain16_i is 1, the corrected sample is multiplied by 16 and saturates to -262144..262143. When gain16_i is 0, the sample passes unchanged.
- R3: When rect_en_i is 1, a negative sample is replaced by its magnitude, and -262144 maps to 262143. When rect_en_i is 0, the sign is kept.
- R4: Before accumulation, each sample is arithmetically shifted right by shift_i (0 to 7), which rounds toward minus infinity.
- R5: After win_len_i accepted samples (a length of 0 acts as 1), result_o holds the sum of the scaled samples and done_o is 1 for exactly the cycle after the clock edge that took the last sample. At all other times result_o holds its value.
- R6: If a window's running sum leaves the 32-bit signed range, the accumulator clamps to 0x7FFFFFFF (positive overflow) or 0x80000000 (negative overflow) and stays there for the rest of that window. ovf_o is set and stays set until the next start.
- R7: If cont_i is 0 when a window ends, busy_o falls and sampling stops. If cont_i is 1, busy_o stays high and a fresh window starts from zero with the next sample.
- R8: A start_i pulse clears the accumulator, the sample count and ovf_o, and sets busy_o on the next cycle. A sample presented in the same cycle as start_i, or while busy_o is 0, is ignored: no done pulse and no change to result_o.
- R9: path_tag_o takes path_sel_i at each start and holds it otherwise. The tag code has no effect on the result.
- R10: After reset, result_o, done_o, ovf_o, busy_o and path_tag_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 19 | Signed decimated sample |
| ofs_hi_i | input | 8 | Upper byte of the correction value |
| ofs_lo_i | input | 8 | Lower byte of the correction value |
| gain16_i | input | 1 | Selects the ×16 gain |
| rect_en_i | input | 1 | Enables the magnitude stage |
| shift_i | input | 3 | Right-shift amount before accumulation |
| win_len_i | input | 16 | Samples per window |
| path_sel_i | input | 4 | Source code latched at start |
| start_i | input | 1 | Starts a measurement |
| cont_i | input | 1 | Continuous-mode select |
| result_o | output | 32 | Latched window result |
| done_o | output | 1 | One-cycle end-of-window pulse |
| ovf_o | output | 1 | Sticky overflow flag |
| busy_o | output | 1 | Measurement active |
| path_tag_o | output | 4 | Latched source tag |

## Verification
The bound checker watches the control sequencing on every cycle:
- done_o appears only after an accepted sample.
- result_o changes only together with done_o.
- ovf_o stays set until a start.
- A start leaves the block busy and clear.
- busy_o after a window end follows the continuous-mode select.
- The tag holds between starts.

The arithmetic needs the directed scenarios. Only they can show the saturating correction and gain stages, the magnitude of the most negative value, shift rounding, window sums, and clamping through long windows that first overflow and then receive samples of the opposite sign.

// File: rtl/dclvl_pkg.sv
package dclvl_pkg;
    typedef enum logic {
        RUN_IDLE = 1'b0,
        RUN_LIVE = 1'b1
    } run_e;
endpackage

// File: rtl/dclvl_condition.sv
module dclvl_condition #(
    parameter int IN_W  = 19,
    parameter int OFS_W = 16,
    parameter int SH_W  = 3
) (
    input  logic signed [IN_W-1:0]  smp_i,
    input  logic signed [OFS_W-1:0] ofs_i,
    input  logic                    gain16_i,
    input  logic                    rect_en_i,
    input  logic [SH_W-1:0]         shift_i,
    output logic signed [IN_W-1:0]  cond_o
);
    localparam int SUM_W = IN_W + 1;
    localparam int G_W   = IN_W + 4;
    localparam logic signed [IN_W-1:0] S_MAX = {1'b0, {(IN_W-1){1'b1}}};
    localparam logic signed [IN_W-1:0] S_MIN = {1'b1, {(IN_W-1){1'b0}}};

    logic signed [SUM_W-1:0] sum;
    logic signed [IN_W-1:0]  corr;
    logic signed [G_W-1:0]   gwide;
    logic signed [IN_W-1:0]  gained;
    logic signed [IN_W-1:0]  mag;

    always_comb begin
        sum = {smp_i[IN_W-1], smp_i} + {{(SUM_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
        if (sum[SUM_W-1] != sum[SUM_W-2]) corr = sum[SUM_W-1] ? S_MIN : S_MAX;
        else                              corr = sum[IN_W-1:0];

        gwide = {corr, 4'b0000};
        if (!gain16_i) begin
            gained = corr;
        end else if (gwide[G_W-1:IN_W-1] != {5{gwide[G_W-1]}}) begin
            gained = gwide[G_W-1] ? S_MIN : S_MAX;
        end else begin
            gained = gwide[IN_W-1:0];
        end

        if (rect_en_i && gained[IN_W-1]) mag = (gained == S_MIN) ? S_MAX : -gained;
        else                             mag = gained;

        cond_o = mag >>> shift_i;
    end
endmodule

// File: rtl/dclvl_satacc.sv
module dclvl_satacc #(
    parameter int ACC_W = 32,
    parameter int IN_W  = 19
) (
    input  logic signed [ACC_W-1:0] acc_i,
    input  logic signed [IN_W-1:0]  add_i,
    output logic signed [ACC_W-1:0] sum_o,
    output logic                    ovf_o
);
    localparam int W = ACC_W + 1;
    localparam logic signed [ACC_W-1:0] A_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] A_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [W-1:0] wide;

    always_comb begin
        wide  = {acc_i[ACC_W-1], acc_i} + {{(W-IN_W){add_i[IN_W-1]}}, add_i};
        ovf_o = (wide[W-1] != wide[W-2]);
        if (ovf_o) sum_o = wide[W-1] ? A_MIN : A_MAX;
        else       sum_o = wide[ACC_W-1:0];
    end
endmodule

// File: rtl/dclvl_integrator.sv
module dclvl_integrator #(
    parameter int IN_W  = 19,
    parameter int OFS_B = 8,
    parameter int SH_W  = 3,
    parameter int CNT_W = 16,
    parameter int ACC_W = 32,
    parameter int TAG_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             smp_valid_i,
    input  logic [IN_W-1:0]  smp_data_i,
    input  logic [OFS_B-1:0] ofs_hi_i,
    input  logic [OFS_B-1:0] ofs_lo_i,
    input  logic             gain16_i,
    input  logic             rect_en_i,
    input  logic [SH_W-1:0]  shift_i,
    input  logic [CNT_W-1:0] win_len_i,
    input  logic [TAG_W-1:0] path_sel_i,
    input  logic             start_i,
    input  logic             cont_i,
    output logic [ACC_W-1:0] result_o,
    output logic             done_o,
    output logic             ovf_o,
    output logic             busy_o,
    output logic [TAG_W-1:0] path_tag_o
);
    import dclvl_pkg::*;

    localparam int OFS_W = 2 * OFS_B;

    typedef struct packed {
        run_e                    run;
        logic [CNT_W-1:0]        cnt;
        logic signed [ACC_W-1:0] acc;
        logic                    win_sat;
        logic [ACC_W-1:0]        result;
        logic                    done;
        logic                    ovf;
        logic [TAG_W-1:0]        tag;
    } state_t;

    state_t st_d, st_q;

    logic signed [IN_W-1:0]  cond_smp;
    logic signed [ACC_W-1:0] add_sum;
    logic                    add_ovf;
    logic [CNT_W:0]          cnt_inc;
    logic                    last_smp;
    logic signed [ACC_W-1:0] acc_next;

    dclvl_condition #(.IN_W(IN_W), .OFS_W(OFS_W), .SH_W(SH_W)) cond_i (
        .smp_i     ($signed(smp_data_i)),
        .ofs_i     ($signed({ofs_hi_i, ofs_lo_i})),
        .gain16_i  (gain16_i),
        .rect_en_i (rect_en_i),
        .shift_i   (shift_i),
        .cond_o    (cond_smp)
    );

    dclvl_satacc #(.ACC_W(ACC_W), .IN_W(IN_W)) acc_i (
        .acc_i (st_q.acc),
        .add_i (cond_smp),
        .sum_o (add_sum),
        .ovf_o (add_ovf)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        cnt_inc   = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        last_smp  = (cnt_inc >= {1'b0, win_len_i});
        acc_next  = st_q.win_sat ? st_q.acc : add_sum;

        if (start_i) begin
            st_d.run     = RUN_LIVE;
            st_d.cnt     = '0;
            st_d.acc     = '0;
            st_d.win_sat = 1'b0;
            st_d.ovf     = 1'b0;
            st_d.tag     = path_sel_i;
        end else if (st_q.run == RUN_LIVE && smp_valid_i) begin
            if (add_ovf && !st_q.win_sat) st_d.ovf = 1'b1;
            if (last_smp) begin
                st_d.result  = acc_next;
                st_d.done    = 1'b1;
                st_d.acc     = '0;
                st_d.cnt     = '0;
                st_d.win_sat = 1'b0;
                st_d.run     = cont_i ? RUN_LIVE : RUN_IDLE;
            end else begin
                st_d.acc     = acc_next;
                st_d.cnt     = cnt_inc[CNT_W-1:0];
                st_d.win_sat = st_q.win_sat | add_ovf;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.run     <= RUN_IDLE;
            st_q.cnt     <= '0;
            st_q.acc     <= '0;
            st_q.win_sat <= 1'b0;
            st_q.result  <= '0;
            st_q.done    <= 1'b0;
            st_q.ovf     <= 1'b0;
            st_q.tag     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o   = st_q.result;
    assign done_o     = st_q.done;
    assign ovf_o      = st_q.ovf;
    assign busy_o     = (st_q.run == RUN_LIVE);
    assign path_tag_o = st_q.tag;
endmodule

module dclvl_integrator_chk #(
    parameter int ACC_W = 32,
    parameter int TAG_W = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             smp_valid_i,
    input logic             start_i,
    input logic             cont_i,
    input logic [TAG_W-1:0] path_sel_i,
    input logic [ACC_W-1:0] result_o,
    input logic             done_o,
    input logic             ovf_o,
    input logic             busy_o,
    input logic [TAG_W-1:0] path_tag_o
);
    p_done_after_sample_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($past(smp_valid_i) && $past(busy_o) && !$past(start_i)));

    p_result_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(result_o));

    p_ovf_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(ovf_o) && !$past(start_i)) |-> ovf_o);

    p_start_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (busy_o && !ovf_o && !done_o && path_tag_o == $past(path_sel_i)));

    p_idle_no_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |=> !done_o);

    p_single_stops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !$past(cont_i)) |-> !busy_o);

    p_cont_keeps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && $past(cont_i)) |-> busy_o);

    p_tag_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(start_i) |-> $stable(path_tag_o));
endmodule

bind dclvl_integrator dclvl_integrator_chk #(.ACC_W(ACC_W), .TAG_W(TAG_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .smp_valid_i (smp_valid_i),
    .start_i     (start_i),
    .cont_i      (cont_i),
    .path_sel_i  (path_sel_i),
    .result_o    (result_o),
    .done_o      (done_o),
    .ovf_o       (ovf_o),
    .busy_o      (busy_o),
    .path_tag_o  (path_tag_o)
);

// File: tb/dclvl_integrator_tb_top.sv
module dclvl_integrator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [18:0] data = '0;
    logic [15:0] ofs = '0;
    logic        gain16 = 1'b0;
    logic        rect = 1'b0;
    logic [2:0]  shift = '0;
    logic [15:0] wlen = 16'd1;
    logic [3:0]  psel = 4'b0100;
    logic        start = 1'b0;
    logic        cont = 1'b0;
    logic [31:0] result;
    logic        done;
    logic        ovf;
    logic        busy;
    logic [3:0]  tag;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit last_done;
    logic [31:0] last_res;

    always #2 clk = ~clk;

    dclvl_integrator dut_i (
        .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(valid), .smp_data_i(data),
        .ofs_hi_i(ofs[15:8]), .ofs_lo_i(ofs[7:0]), .gain16_i(gain16),
        .rect_en_i(rect), .shift_i(shift), .win_len_i(wlen), .path_sel_i(psel),
        .start_i(start), .cont_i(cont), .result_o(result), .done_o(done),
        .ovf_o(ovf), .busy_o(busy), .path_tag_o(tag)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint clamp19(input longint v);
        if (v > 262143)  return 262143;
        if (v < -262144) return -262144;
        return v;
    endfunction

    function automatic longint model(input longint s, input longint o, input bit g,
                                     input bit r, input int k);
        longint v;
        v = clamp19(s + o);
        if (g) v = clamp19(v * 16);
        if (r && v < 0) v = clamp19(-v);
        v = v >>> k;
        return v;
    endfunction

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send(input longint s, input int gap);
        data  = s[18:0];
        valid = 1'b1;
        @(negedge clk);
        last_done = done;
        last_res  = result;
        valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic one_shot(input string req, input longint s, input longint o,
                            input bit g, input bit r, input int k);
        ofs = o[15:0]; gain16 = g; rect = r; shift = k[2:0]; wlen = 16'd1; cont = 1'b0;
        do_start();
        send(s, 1);
        chk({req, " done"}, last_done, 1);
        chk({req, " value"}, longint'($signed(last_res)), model(s, o, g, r, k));
    endtask

    task automatic t_reset();
        chk("R10 result", result, 0);
        chk("R10 done", done, 0);
        chk("R10 ovf", ovf, 0);
        chk("R10 busy", busy, 0);
        chk("R10 tag", tag, 0);
    endtask

    task automatic t_offset();
        one_shot("R1 plain", 1000, -300, 0, 0, 0);
        one_shot("R1 sat hi", 262000, 1000, 0, 0, 0);
        one_shot("R1 sat lo", -262000, -1000, 0, 0, 0);
        one_shot("R1 neg ofs", 5, -32768, 0, 0, 0);
    endtask

    task automatic t_gain();
        one_shot("R2 x16", 100, 0, 1, 0, 0);
        one_shot("R2 sat hi", 20000, 0, 1, 0, 0);
        one_shot("R2 sat lo", -20000, 0, 1, 0, 0);
        one_shot("R2 off", -20000, 0, 0, 0, 0);
    endtask

    task automatic t_rect();
        one_shot("R3 abs", -500, 0, 0, 1, 0);
        one_shot("R3 minval", -262144, 0, 0, 1, 0);
        one_shot("R3 off", -500, 0, 0, 0, 0);
        one_shot("R3 gain chain", -20000, 0, 1, 1, 0);
    endtask

    task automatic t_shift();
        one_shot("R4 pos", 100, 0, 0, 0, 3);
        one_shot("R4 neg floor", -100, 0, 0, 0, 3);
        one_shot("R4 k7", 262143, 0, 0, 0, 7);
    endtask

    task automatic t_window();
        longint exp;
        ofs = 0; gain16 = 0; rect = 0; shift = 0; wlen = 16'd5; cont = 1'b0;
        do_start();
        send(10, 1);  chk("R5 no early done", last_done, 0);
        send(-3, 1);
        send(7, 1);
        send(100, 1); chk("R5 no early done 4", last_done, 0);
        send(-50, 1);
        exp = 64;
        chk("R5 done", last_done, 1);
        chk("R5 sum", longint'($signed(last_res)), exp);
        chk("R5 done one cycle", done, 0);
        chk("R7 single stops", busy, 0);
        send(999, 1);
        chk("R8 idle ignored done", last_done, 0);
        chk("R8 idle ignored result", longint'($signed(result)), exp);
        wlen = 16'd0;
        do_start();
        send(42, 1);
        chk("R5 len0 done", last_done, 1);
        chk("R5 len0 value", longint'($signed(last_res)), 42);
    endtask

    task automatic t_cont();
        ofs = 0; shift = 0; gain16 = 0; rect = 0; wlen = 16'd3; cont = 1'b1;
        do_start();
        send(1, 0); send(2, 0); send(3, 0);
        chk("R7 cont w1", longint'($signed(last_res)), 6);
        chk("R7 cont busy", busy, 1);
        send(10, 0); send(20, 0);
        chk("R7 cont mid", last_done, 0);
        cont = 1'b0;
        send(30, 0);
        chk("R7 cont w2", longint'($signed(last_res)), 60);
        chk("R7 stop after", busy, 0);
    endtask

    task automatic t_restart();
        wlen = 16'd4; cont = 1'b0; shift = 0;
        do_start();
        send(100, 0); send(100, 0);
        start = 1'b1; data = 19'd5000; valid = 1'b1;
        @(negedge clk);
        start = 1'b0; valid = 1'b0;
        send(1, 0); send(2, 0); send(3, 0);
        chk("R8 restart not done", last_done, 0);
        send(4, 0);
        chk("R8 restart sum", longint'($signed(last_res)), 10);
    endtask

    task automatic t_ovf_pos();
        ofs = 0; gain16 = 0; rect = 0; shift = 0; cont = 1'b0; wlen = 16'd9000;
        do_start();
        chk("R8 start clears ovf", ovf, 0);
        for (int i = 0; i < 8200; i++) send(262143, 0);
        chk("R6 ovf set", ovf, 1);
        for (int i = 0; i < 800; i++) send(-262144, 0);
        chk("R6 pos done", last_done, 1);
        chk("R6 pos clamp", last_res, 64'h7FFFFFFF);
        chk("R6 ovf sticky", ovf, 1);
    endtask

    task automatic t_ovf_neg();
        wlen = 16'd8500;
        do_start();
        chk("R8 start clears ovf 2", ovf, 0);
        for (int i = 0; i < 8500; i++) send(-262144, 0);
        chk("R6 neg clamp", last_res, 64'h80000000);
        chk("R6 neg ovf", ovf, 1);
        wlen = 16'd8192;
        do_start();
        for (int i = 0; i < 8192; i++) send(-262144, 0);
        chk("R6 exact min no ovf", ovf, 0);
        chk("R6 exact min value", last_res, 64'h80000000);
    endtask

    task automatic t_tag();
        wlen = 16'd1; shift = 0; ofs = 0;
        psel = 4'b1010;
        do_start();
        chk("R9 tag latched", tag, 4'b1010);
        psel = 4'b1111;
        send(77, 1);
        chk("R9 tag held", tag, 4'b1010);
        chk("R9 value a", longint'($signed(last_res)), 77);
        do_start();
        chk("R9 tag new", tag, 4'b1111);
        send(77, 1);
        chk("R9 value same", longint'($signed(last_res)), 77);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_offset();
        t_gain();
        t_rect();
        t_shift();
        t_window();
        t_cont();
        t_restart();
        t_ovf_pos();
        t_ovf_neg();
        t_tag();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule